// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block is the register mailbox that sits between a host processor and a security coprocessor. The host fills a bank of request registers through a 32-bit word-addressed read/write port. It then raises a request-valid flag and, optionally, an interrupt enable in the control word. The coprocessor sees the latched request fields and the request-valid flag on a parallel port. When it has finished, it posts its reply fields with a single set strobe.

Posting a reply raises response-valid. If the interrupt is enabled, this drives a level interrupt to the host. The host reads the reply bank and the status word, then writes the response-done bit of the control word. That write closes the transaction and returns the mailbox to idle. Only one command is in flight at a time. The status word also carries a reply-check bit, so the host can see at once whether the reply indicates success.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset every register reads 0, `host_irq`, `host_rvalid` and `cop_req_valid` are low, and `host_rdata` is 0.
- R2: The six request words sit at byte offsets 0x800 opcode, 0x804 format flag, 0x808 client id, 0x80C buffer address low, 0x810 buffer address high and 0x814 message size. Each one is written by the host, reads back the written value, and drives its own `cop_req_*` output.
- R3: The control word at offset 0x4 holds request-valid in bit 0 and interrupt enable in bit 8, and both read back as written. Bit 4, response-done, always reads 0. `cop_req_valid` follows bit 0.
- R4: While request-valid is set, host writes to the request words are ignored. Once it is clear, they take effect again.
- R5: A `cop_rsp_set` pulse while no reply is pending latches the reply opcode, format flag and status. These read back at 0x1000, 0x1004 and 0x1008. The same pulse sets response-valid, which is bit 0 of the read-only status word at 0x8.
- R6: A `cop_rsp_set` pulse while a reply is already pending is ignored, and the reply words keep their earlier values.
- R7: `host_irq` is high exactly when response-valid and the interrupt enable are both set.
- R8: A host write to 0x4 with bit 4 set clears response-valid and request-valid, and loads the interrupt enable from bit 8. `host_irq` is low from the cycle after that write.
- R9: A read strobe returns its data on `host_rdata` one cycle later, with `host_rvalid` high for that one cycle. Unmapped offsets read 0, and host writes to the status word at 0x8 have no effect.
- R10: Status bit 1 is set only when a reply is pending, its status is 0, its opcode equals the request opcode, and its format flag equals 0x50530001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 13 | Host byte offset (word aligned) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the strobe |
| host_rvalid | output | 1 | Read data valid |
| host_irq | output | 1 | Level reply interrupt |
| cop_req_valid | output | 1 | Request pending for the coprocessor |
| cop_req_opcode | output | 32 | Latched request opcode |
| cop_req_format | output | 32 | Latched request format flag |
| cop_req_client | output | 32 | Latched client id |
| cop_req_addr_lo | output | 32 | Latched buffer address, low word |
| cop_req_addr_hi | output | 32 | Latched buffer address, high word |
| cop_req_size | output | 32 | Latched message size in bytes |
| cop_rsp_set | input | 1 | Reply post strobe |
| cop_rsp_opcode | input | 32 | Reply opcode |
| cop_rsp_format | input | 32 | Reply format flag |
| cop_rsp_status | input | 32 | Reply status word |
| cop_rsp_pending | output | 1 | Reply posted and not yet acknowledged |

## Verification
Host reads are due on the falling edge after the rising edge that samples the strobe. The bench therefore queues the expected word when it raises the strobe, and a monitor on the falling edge pops and compares it whenever `host_rvalid` is high. Register writes and reply posts act at the single rising edge that samples them. Their effects on `host_irq`, `cop_req_valid` and `cop_rsp_pending` are checked at the very next falling edge, without waiting any longer. Ignored writes and ignored reply posts are confirmed by reading back the register they would have changed, before any later stimulus can touch it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int          REQ_NUM      = 6;
   localparam logic [15:0] OFF_CTRL     = 16'h0004;
   localparam logic [15:0] OFF_STAT     = 16'h0008;
   localparam logic [15:0] OFF_REQ_BASE = 16'h0800;
   localparam logic [15:0] OFF_RSP_OPC  = 16'h1000;
   localparam logic [15:0] OFF_RSP_FMT  = 16'h1004;
   localparam logic [15:0] OFF_RSP_STS  = 16'h1008;
   localparam int          CTRL_REQ_BIT  = 0;
   localparam int          CTRL_DONE_BIT = 4;
   localparam int          CTRL_IEN_BIT  = 8;
   localparam logic [31:0] FMT_MAGIC    = 32'h5053_0001;

   typedef enum logic [2:0] {
      REQ_OPCODE  = 3'd0,
      REQ_FORMAT  = 3'd1,
      REQ_CLIENT  = 3'd2,
      REQ_ADDR_LO = 3'd3,
      REQ_ADDR_HI = 3'd4,
      REQ_SIZE    = 3'd5
   } req_word_e;

   function automatic logic [15:0] req_off(input int idx);
      return OFF_REQ_BASE + 16'(idx * 4);
   endfunction
endpackage

// File: rtl/mbx_req_bank.sv
module mbx_req_bank
   import mbx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 13
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [DATA_W-1:0]              wdata,
   input  logic                           lock,
   output logic [REQ_NUM-1:0][DATA_W-1:0] words
);
   for (genvar i = 0; i < REQ_NUM; i++) begin : g_word
      logic sel;
      assign sel = wr_en && (addr == ADDR_W'(req_off(i)));

      always_ff @(posedge clk) begin
         if (!rst_n)            words[i] <= '0;
         else if (sel && !lock) words[i] <= wdata;
      end

      AST_REQ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
         (sel && lock) |=> $stable(words[i])); // R4
   end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
   import mbx_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wbit_req,
   input  logic              wbit_done,
   input  logic              wbit_ien,
   input  logic              rsp_valid,
   output logic              req_valid,
   output logic              irq_en,
   output logic              done_pulse,
   output logic              irq
);
   logic ctrl_sel;
   assign ctrl_sel   = wr_en && (addr == ADDR_W'(OFF_CTRL));
   assign done_pulse = ctrl_sel && wbit_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         irq_en    <= 1'b0;
      end else if (ctrl_sel) begin
         req_valid <= wbit_done ? 1'b0 : wbit_req;
         irq_en    <= wbit_ien;
      end
   end

   assign irq = rsp_valid && irq_en;

   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !irq); // R8
   AST_DONE_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !req_valid); // R8
endmodule

// File: rtl/mbx_rsp_bank.sv
module mbx_rsp_bank
   import mbx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic              clr,
   input  logic [DATA_W-1:0] in_opcode,
   input  logic [DATA_W-1:0] in_format,
   input  logic [DATA_W-1:0] in_status,
   input  logic [DATA_W-1:0] req_opcode,
   output logic              valid,
   output logic [DATA_W-1:0] opcode,
   output logic [DATA_W-1:0] format,
   output logic [DATA_W-1:0] status,
   output logic              reply_ok
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         opcode <= '0;
         format <= '0;
         status <= '0;
      end else if (valid && clr) begin
         valid <= 1'b0;
      end else if (set && !valid) begin
         valid  <= 1'b1;
         opcode <= in_opcode;
         format <= in_format;
         status <= in_status;
      end
   end

   assign reply_ok = valid && (status == '0) && (opcode == req_opcode)
                     && (format == DATA_W'(FMT_MAGIC));

   AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && set && !clr) |=> ($stable(opcode) && $stable(status) && $stable(format) && valid)); // R6
   AST_RSP_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !valid) |=> valid); // R5
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
   import mbx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_en,
   input  logic              host_rd_en,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid,
   output logic              host_irq,
   output logic              cop_req_valid,
   output logic [DATA_W-1:0] cop_req_opcode,
   output logic [DATA_W-1:0] cop_req_format,
   output logic [DATA_W-1:0] cop_req_client,
   output logic [DATA_W-1:0] cop_req_addr_lo,
   output logic [DATA_W-1:0] cop_req_addr_hi,
   output logic [DATA_W-1:0] cop_req_size,
   input  logic              cop_rsp_set,
   input  logic [DATA_W-1:0] cop_rsp_opcode,
   input  logic [DATA_W-1:0] cop_rsp_format,
   input  logic [DATA_W-1:0] cop_rsp_status,
   output logic              cop_rsp_pending
);
   if (DATA_W != 32) begin : g_bad_width
      $error("cmd_mailbox: DATA_W must be 32 to hold the format flag");
   end
   if (ADDR_W < 13) begin : g_bad_addr
      $error("cmd_mailbox: ADDR_W must reach the reply bank at 0x1008");
   end

   logic [REQ_NUM-1:0][DATA_W-1:0] req_words;
   logic req_valid, irq_en, done_pulse, rsp_valid, reply_ok;
   logic [DATA_W-1:0] rsp_opcode, rsp_format, rsp_status;

   mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .addr(host_addr),
      .wbit_req(host_wdata[CTRL_REQ_BIT]), .wbit_done(host_wdata[CTRL_DONE_BIT]),
      .wbit_ien(host_wdata[CTRL_IEN_BIT]), .rsp_valid(rsp_valid),
      .req_valid(req_valid), .irq_en(irq_en), .done_pulse(done_pulse), .irq(host_irq)
   );

   mbx_req_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_req (
      .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .addr(host_addr),
      .wdata(host_wdata), .lock(req_valid), .words(req_words)
   );

   mbx_rsp_bank #(.DATA_W(DATA_W)) u_rsp (
      .clk(clk), .rst_n(rst_n), .set(cop_rsp_set), .clr(done_pulse),
      .in_opcode(cop_rsp_opcode), .in_format(cop_rsp_format), .in_status(cop_rsp_status),
      .req_opcode(req_words[REQ_OPCODE]), .valid(rsp_valid),
      .opcode(rsp_opcode), .format(rsp_format), .status(rsp_status), .reply_ok(reply_ok)
   );

   assign cop_req_valid   = req_valid;
   assign cop_req_opcode  = req_words[REQ_OPCODE];
   assign cop_req_format  = req_words[REQ_FORMAT];
   assign cop_req_client  = req_words[REQ_CLIENT];
   assign cop_req_addr_lo = req_words[REQ_ADDR_LO];
   assign cop_req_addr_hi = req_words[REQ_ADDR_HI];
   assign cop_req_size    = req_words[REQ_SIZE];
   assign cop_rsp_pending = rsp_valid;

   logic [DATA_W-1:0] rd_next;
   logic              rd_hit;
   always_comb begin
      rd_next = '0;
      rd_hit  = 1'b0;
      if (host_addr == ADDR_W'(OFF_CTRL)) begin
         rd_hit = 1'b1;
         rd_next[CTRL_REQ_BIT] = req_valid;
         rd_next[CTRL_IEN_BIT] = irq_en;
      end else if (host_addr == ADDR_W'(OFF_STAT)) begin
         rd_hit = 1'b1;
         rd_next[0] = rsp_valid;
         rd_next[1] = reply_ok;
      end else if (host_addr == ADDR_W'(OFF_RSP_OPC)) begin
         rd_hit = 1'b1; rd_next = rsp_opcode;
      end else if (host_addr == ADDR_W'(OFF_RSP_FMT)) begin
         rd_hit = 1'b1; rd_next = rsp_format;
      end else if (host_addr == ADDR_W'(OFF_RSP_STS)) begin
         rd_hit = 1'b1; rd_next = rsp_status;
      end else begin
         for (int i = 0; i < REQ_NUM; i++) begin
            if (host_addr == ADDR_W'(req_off(i))) begin
               rd_hit  = 1'b1;
               rd_next = req_words[i];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rdata  <= '0;
         host_rvalid <= 1'b0;
      end else begin
         host_rvalid <= host_rd_en;
         if (host_rd_en) host_rdata <= rd_next;
      end
   end

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_en |=> host_rvalid); // R9
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_en && !rd_hit) |=> (host_rdata == '0)); // R9
   AST_IRQ_NEEDS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> cop_rsp_pending); // R7
endmodule

// File: tb/cmd_mailbox_bench.sv
`timescale 1ns/1ps
module cmd_mailbox_bench;
   localparam logic [31:0] MAGIC = 32'h5053_0001;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_wr_en = 1'b0, host_rd_en = 1'b0;
   logic [12:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic host_rvalid, host_irq, cop_req_valid, cop_rsp_pending;
   logic [31:0] cop_req_opcode, cop_req_format, cop_req_client;
   logic [31:0] cop_req_addr_lo, cop_req_addr_hi, cop_req_size;
   logic cop_rsp_set = 1'b0;
   logic [31:0] cop_rsp_opcode = '0, cop_rsp_format = '0, cop_rsp_status = '0;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   cmd_mailbox u_cmd_mailbox (
      .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .host_irq(host_irq), .cop_req_valid(cop_req_valid),
      .cop_req_opcode(cop_req_opcode), .cop_req_format(cop_req_format),
      .cop_req_client(cop_req_client), .cop_req_addr_lo(cop_req_addr_lo),
      .cop_req_addr_hi(cop_req_addr_hi), .cop_req_size(cop_req_size),
      .cop_rsp_set(cop_rsp_set), .cop_rsp_opcode(cop_rsp_opcode),
      .cop_rsp_format(cop_rsp_format), .cop_rsp_status(cop_rsp_status),
      .cop_rsp_pending(cop_rsp_pending)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compare read data one cycle after each strobe
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         if (exp_q.size() == 0) begin
            chk(host_rdata, 32'hxxxx_xxxx, "R9 unexpected read data");
         end else begin
            chk(host_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic wr(input logic [12:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr_en = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [12:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      host_rd_en = 1'b1; host_addr = a;
      @(negedge clk);
      host_rd_en = 1'b0;
   endtask

   task automatic post(input logic [31:0] op, input logic [31:0] fmt, input logic [31:0] st);
      @(negedge clk);
      cop_rsp_set = 1'b1; cop_rsp_opcode = op; cop_rsp_format = fmt; cop_rsp_status = st;
      @(negedge clk);
      cop_rsp_set = 1'b0;
   endtask

   initial begin
      #(5.0 * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({31'd0, host_irq}, 32'd0, "R1 irq after reset");
      chk({31'd0, cop_req_valid}, 32'd0, "R1 req valid after reset");
      chk({31'd0, host_rvalid}, 32'd0, "R1 rvalid after reset");
      chk(host_rdata, 32'd0, "R1 rdata after reset");
      rd(13'h004, 32'd0, "R1 ctrl reset");
      rd(13'h008, 32'd0, "R1 status reset");
      rd(13'h800, 32'd0, "R1 opcode reset");
      rd(13'h1008, 32'd0, "R1 reply status reset");

      // R2 request words
      for (int i = 0; i < 6; i++) wr(13'(13'h800 + 4 * i), 32'hA000_0010 + i);
      for (int i = 0; i < 6; i++) rd(13'(13'h800 + 4 * i), 32'hA000_0010 + i, "R2 request readback");
      chk(cop_req_opcode,  32'hA000_0010, "R2 cop opcode");
      chk(cop_req_format,  32'hA000_0011, "R2 cop format");
      chk(cop_req_client,  32'hA000_0012, "R2 cop client");
      chk(cop_req_addr_lo, 32'hA000_0013, "R2 cop addr lo");
      chk(cop_req_addr_hi, 32'hA000_0014, "R2 cop addr hi");
      chk(cop_req_size,    32'hA000_0015, "R2 cop size");

      // R3 control word
      wr(13'h004, 32'h0000_0101);
      chk({31'd0, cop_req_valid}, 32'd1, "R3 cop_req_valid follows bit 0");
      rd(13'h004, 32'h0000_0101, "R3 ctrl readback");

      // R4 locked request words
      wr(13'h800, 32'hDEAD_BEEF);
      wr(13'h814, 32'h1234_5678);
      rd(13'h800, 32'hA000_0010, "R4 opcode locked");
      rd(13'h814, 32'hA000_0015, "R4 size locked");
      chk(cop_req_opcode, 32'hA000_0010, "R4 cop opcode unchanged");

      // R9 unmapped and read-only
      rd(13'h000C, 32'd0, "R9 unmapped 0x00C");
      rd(13'h1FFC, 32'd0, "R9 unmapped 0x1FFC");
      wr(13'h008, 32'hFFFF_FFFF);
      rd(13'h008, 32'd0, "R9 status not writable");

      // R5 / R7 / R10 good reply
      post(32'hA000_0010, MAGIC, 32'd0);
      chk({31'd0, host_irq}, 32'd1, "R7 irq on reply with enable");
      chk({31'd0, cop_rsp_pending}, 32'd1, "R5 pending after post");
      rd(13'h008, 32'h3, "R10 status valid+ok");
      rd(13'h1000, 32'hA000_0010, "R5 reply opcode");
      rd(13'h1004, MAGIC, "R5 reply format");
      rd(13'h1008, 32'd0, "R5 reply status");

      // R6 second post ignored
      post(32'h0000_0077, 32'h1, 32'h9);
      rd(13'h1000, 32'hA000_0010, "R6 opcode kept");
      rd(13'h1008, 32'd0, "R6 status kept");

      // R8 done
      wr(13'h004, 32'h0000_0111);
      chk({31'd0, host_irq}, 32'd0, "R8 irq dropped");
      chk({31'd0, cop_req_valid}, 32'd0, "R8 req valid cleared");
      chk({31'd0, cop_rsp_pending}, 32'd0, "R8 pending cleared");
      rd(13'h004, 32'h0000_0100, "R8 ctrl after done");
      rd(13'h008, 32'd0, "R8 status after done");

      // R4 unlocked again
      wr(13'h800, 32'h0000_0042);
      rd(13'h800, 32'h0000_0042, "R4 write accepted when idle");

      // R7 / R10 bad status, interrupt disabled
      wr(13'h004, 32'h0000_0001);
      post(32'h0000_0042, MAGIC, 32'd5);
      chk({31'd0, host_irq}, 32'd0, "R7 no irq with enable clear");
      rd(13'h008, 32'h1, "R10 nonzero status not ok");
      wr(13'h004, 32'h0000_0010);

      // R10 opcode mismatch
      wr(13'h004, 32'h0000_0101);
      post(32'h0000_0043, MAGIC, 32'd0);
      chk({31'd0, host_irq}, 32'd1, "R7 irq with enable");
      rd(13'h008, 32'h1, "R10 opcode mismatch not ok");
      wr(13'h004, 32'h0000_0110);

      // R10 format mismatch
      wr(13'h004, 32'h0000_0101);
      post(32'h0000_0042, 32'h5053_0002, 32'd0);
      rd(13'h008, 32'h1, "R10 format mismatch not ok");
      wr(13'h004, 32'h0000_0010);
      rd(13'h008, 32'd0, "R8 cleared with enable off");

      repeat (3) @(negedge clk);
      chk(32'(exp_q.size()), 32'd0, "R9 all reads returned");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule